// File: doc/BRIEF.md
# Register Stack with Full and Empty Flags

This block is a last-in, first-out store of 64 words of 8 bits, held in registers and addressed by a 6-bit stack pointer. A client pushes a word by pulsing `push_i` with the value on `din_i`, and pops the most recent word by pulsing `pop_i`. The popped word appears on the registered output `dout_o` and stays there until the next successful pop. Two flags, `full_o` and `empty_o`, report the occupancy.

A push advances the pointer first and then writes the word at the new pointer. A pop reads the word at the current pointer and then moves the pointer back. Because the pointer wraps modulo 64, word 0 holds the 64th item. Both flags are therefore taken from the pointer landing on 0 after the move:
- After a push, landing on 0 means full.
- After a pop, landing on 0 means empty.

The block refuses a request it cannot honour and pulses `err_o` for one cycle. This covers a push when full, a pop when empty, and a push and pop in the same cycle. A refused request leaves the pointer, the flags, the stored words and `dout_o` unchanged.

Top module: `reg_stack`

## Requirements
- R1: After the active-low asynchronous reset, `empty_o`=1, `full_o`=0, `err_o`=0 and `dout_o`=0.
- R2: A push accepted on a rising edge clears `empty_o` from that edge on and stores `din_i` as the new top word.
- R3: `full_o` rises on the edge of the 64th accepted push without an intervening pop, and stays 0 after each of the first 63.
- R4: A pop accepted on a rising edge loads `dout_o` with the most recently pushed word not yet popped, and clears `full_o`.
- R5: `empty_o` rises on the edge of the pop that removes the last stored word, and stays 0 while any word remains.
- R6: A push while `full_o`=1 is refused: `err_o` is 1 for exactly the following cycle, `full_o` stays 1 and the stored words are unchanged.
- R7: A pop while `empty_o`=1 is refused: `err_o` is 1 for the following cycle, `empty_o` stays 1 and `dout_o` is unchanged.
- R8: `push_i` and `pop_i` both high in one cycle is refused: `err_o` is 1 for the following cycle, and the flags, stored words and `dout_o` are unchanged.
- R9: `err_o` is 0 in the cycle after any accepted push, accepted pop or idle cycle.
- R10: `dout_o` changes only on the edge of an accepted pop.
- R11: `full_o` and `empty_o` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request for this cycle |
| pop_i | input | 1 | Pop request for this cycle |
| din_i | input | 8 | Word to push |
| dout_o | output | 8 | Last popped word, registered |
| full_o | output | 1 | All 64 words occupied |
| empty_o | output | 1 | No words stored |
| err_o | output | 1 | One-cycle pulse after a refused request |

## Verification
The bench fills all 64 words and drains them again. It checks the flags after every step, so a design that decides full at pointer 63, or that lets the pointer wrap, raises `full_o` one push early or reports empty when 64 words are stored. The drain compares each popped word against arithmetically generated push data. This catches an off-by-one between write address and read address: such a design returns a neighbour word, or loses the word at location 0.

The bench also makes refused requests and then drains the stack:
- A push at full, to show that a design which still writes would corrupt location 1.
- A pop at empty, to show that a design which still reads would disturb `dout_o`.
- A simultaneous push and pop, to show that a design which prioritises one of them would alter the count.

A mixed push and pop sequence, checked against a model stack, catches pointer drift across direction changes.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_BAD  = 2'd3
  } stk_op_e;

  // classify a request against current occupancy
  function automatic stk_op_e classify(input logic push, input logic pop,
                                       input logic full, input logic empty);
    if (push && pop)       return OP_BAD;
    else if (push && full) return OP_BAD;
    else if (pop && empty) return OP_BAD;
    else if (push)         return OP_PUSH;
    else if (pop)          return OP_POP;
    else                   return OP_IDLE;
  endfunction
endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              err_o
);
  localparam logic [ADDR_W-1:0] PTR_ONE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] PTR_ZERO = '0;

  logic [ADDR_W-1:0] sp_q, sp_inc, sp_dec;
  logic              full_q, empty_q, err_q;
  stk_op_e           op;

  assign op     = classify(push_i, pop_i, full_q, empty_q);
  assign sp_inc = sp_q + PTR_ONE;
  assign sp_dec = sp_q - PTR_ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q    <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      err_q <= (op == OP_BAD);
      unique case (op)
        OP_PUSH: begin
          sp_q    <= sp_inc;
          empty_q <= 1'b0;
          full_q  <= (sp_inc == PTR_ZERO);
        end
        OP_POP: begin
          sp_q    <= sp_dec;
          full_q  <= 1'b0;
          empty_q <= (sp_dec == PTR_ZERO);
        end
        default: ;
      endcase
    end
  end

  // pre-increment write, read before post-decrement
  assign wr_en_o   = (op == OP_PUSH);
  assign wr_addr_o = sp_inc;
  assign rd_en_o   = (op == OP_POP);
  assign rd_addr_o = sp_q;
  assign full_o    = full_q;
  assign empty_o   = empty_q;
  assign err_o     = err_q;

  a_r11_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  a_r2_push_clears_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !full_o) |=> !empty_o);

  a_r4_pop_clears_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !empty_o) |=> !full_o);

  a_r6_push_at_full_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o) |=> (err_o && full_o && sp_q == $past(sp_q)));

  a_r7_pop_at_empty_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o) |=> (err_o && empty_o && sp_q == $past(sp_q)));

  a_r8_both_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> (err_o && sp_q == $past(sp_q)));

  a_r9_no_err_on_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(push_i && pop_i) && !(push_i && full_o) && !(pop_i && empty_o)) |=> !err_o);

  a_r8_ports_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_o && rd_en_o));
endmodule

// File: rtl/stk_mem.sv
module stk_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] word_q [DEPTH];
  logic [DATA_W-1:0] rd_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_addr_i == ADDR_W'(g))) word_q[g] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= word_q[rd_addr_i];
  end

  assign rd_data_o = rd_q;

  a_r10_dout_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/reg_stack.sv
module reg_stack #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              err_o
);
  logic              wr_en, rd_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;

  stk_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (push_i),
    .pop_i    (pop_i),
    .wr_en_o  (wr_en),
    .wr_addr_o(wr_addr),
    .rd_en_o  (rd_en),
    .rd_addr_o(rd_addr),
    .full_o   (full_o),
    .empty_o  (empty_o),
    .err_o    (err_o)
  );

  stk_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(din_i),
    .rd_en_i  (rd_en),
    .rd_addr_i(rd_addr),
    .rd_data_o(dout_o)
  );

  a_r1_err_low_after_reset: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> !err_o);
endmodule

// File: tb/reg_stack_bench.sv
module reg_stack_bench;
  localparam int DW    = 8;
  localparam int DEPTH = 64;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          push_i = 1'b0;
  logic          pop_i = 1'b0;
  logic [DW-1:0] din_i = '0;
  logic [DW-1:0] dout_o;
  logic          full_o, empty_o, err_o;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [DEPTH];
  int depth = 0;
  logic [DW-1:0] last_out = '0;

  always #5 clk_i = ~clk_i;

  reg_stack u_reg_stack (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push_i), .pop_i(pop_i),
    .din_i(din_i), .dout_o(dout_o), .full_o(full_o), .empty_o(empty_o),
    .err_o(err_o)
  );

  task automatic check(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one cycle of stimulus; sample 2 ns after the edge
  task automatic cyc(input logic p, input logic q, input logic [DW-1:0] d);
    push_i = p; pop_i = q; din_i = d;
    @(posedge clk_i); #2;
    push_i = 1'b0; pop_i = 1'b0;
  endtask

  // accepted push with model update and flag checks
  task automatic do_push(input logic [DW-1:0] d);
    cyc(1'b1, 1'b0, d);
    model[depth] = d; depth++;
    check(int'(empty_o), 0, "R2", "empty after push");
    check(int'(full_o), (depth == DEPTH) ? 1 : 0, "R3", "full after push");
    check(int'(err_o), 0, "R9", "err after push");
    check(int'(full_o && empty_o), 0, "R11", "flags exclusive");
  endtask

  task automatic do_pop();
    cyc(1'b0, 1'b1, '0);
    depth--; last_out = model[depth];
    check(int'(dout_o), int'(last_out), "R4", "popped word");
    check(int'(full_o), 0, "R4", "full after pop");
    check(int'(empty_o), (depth == 0) ? 1 : 0, "R5", "empty after pop");
    check(int'(err_o), 0, "R9", "err after pop");
    check(int'(full_o && empty_o), 0, "R11", "flags exclusive");
  endtask

  task automatic idle_check();
    cyc(1'b0, 1'b0, 8'hA5);
    check(int'(err_o), 0, "R9", "err after idle");
    check(int'(dout_o), int'(last_out), "R10", "dout held on idle");
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk_i);
    #2;
    check(int'(empty_o), 1, "R1", "reset empty");
    check(int'(full_o), 0, "R1", "reset full");
    check(int'(err_o), 0, "R1", "reset err");
    check(int'(dout_o), 0, "R1", "reset dout");
    rst_ni = 1'b1;
    #3;

    // R7: pop on empty after reset
    cyc(1'b0, 1'b1, '0);
    check(int'(err_o), 1, "R7", "err on pop at empty");
    check(int'(empty_o), 1, "R7", "still empty");
    check(int'(dout_o), 0, "R7", "dout unchanged");
    idle_check();

    // fill all 64 words (R2, R3)
    for (int i = 0; i < DEPTH; i++) do_push(DW'(i * 37 + 5));

    // R6: push while full, distinct data
    cyc(1'b1, 1'b0, 8'hEE);
    check(int'(err_o), 1, "R6", "err on push at full");
    check(int'(full_o), 1, "R6", "full held");
    cyc(1'b0, 1'b0, '0);
    check(int'(err_o), 0, "R6", "err single pulse");

    // R8 while full
    cyc(1'b1, 1'b1, 8'h11);
    check(int'(err_o), 1, "R8", "err on both at full");
    check(int'(full_o), 1, "R8", "full held on both");
    check(int'(dout_o), 0, "R8", "dout held on both");

    // drain completely, verifying contents untouched (R4, R5, R6, R10)
    for (int k = 0; k < DEPTH; k++) begin
      do_pop();
      if (k % 8 == 0) idle_check();
    end

    // R7 after drain: dout kept
    cyc(1'b0, 1'b1, '0);
    check(int'(err_o), 1, "R7", "err on pop after drain");
    check(int'(empty_o), 1, "R7", "empty after drain");
    check(int'(dout_o), int'(last_out), "R7", "dout kept after refused pop");

    // R8 while empty: no push taken
    cyc(1'b1, 1'b1, 8'h77);
    check(int'(err_o), 1, "R8", "err on both at empty");
    check(int'(empty_o), 1, "R8", "empty kept on both");

    // R8 mid-stack, then mixed pattern against model
    for (int i = 0; i < 3; i++) do_push(DW'(8'hC0 + i));
    cyc(1'b1, 1'b1, 8'h99);
    check(int'(err_o), 1, "R8", "err on both mid-stack");
    check(int'(dout_o), int'(last_out), "R8", "dout held mid-stack");
    do_pop(); do_pop();
    for (int i = 0; i < 5; i++) do_push(DW'(200 - i * 11));
    idle_check();
    while (depth > 0) do_pop();

    // wrap a second time to exercise location 0 reuse
    for (int i = 0; i < DEPTH; i++) do_push(DW'(255 - i * 3));
    for (int k = 0; k < DEPTH; k++) do_pop();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule